// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is an eight-pin general-purpose I/O port that sits on a plain memory-mapped register bus. The bus has an address, a write enable, a byte of write data and a byte of read data. Reads are combinational. Each pin has a direction bit. The pin can be driven by an output-data register, or its level can be sampled from the pad through a two-flop synchronizer.

The data register has no separate mask register. Its masking comes from the address. Any access into the lower 1 KiB data window uses address bits [9:2] as a per-bit mask. A write changes only the selected bits, and a read shows only the selected bits. Software can therefore set, clear or test a single pin with one bus access and no read-modify-write.

A pin that is currently an input does not accept data writes. Software that wants a defined level on a pin must first make the pin an output, then write the level.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset the direction register and the output-data register are all zeros. `padOe` and `padOut` are 0, and a direction read returns 0.
- R2: A write to byte offset 0x400 loads all eight direction bits. A read of 0x400 returns all eight bits. `padOe[n]` equals direction bit n, where 1 means output.
- R3: An access is in the data window when address bits [11:10] are 00. A write there updates output-data bit n only when address bit n+2 is 1 and pin n is an output. Every other bit keeps its value.
- R4: A data write to a pin that is an input leaves that pin's output-data bit unchanged. After the pin is switched to output, the pad shows the earlier value until a new write occurs.
- R5: On a data-window read, read-data bit n is 0 whenever address bit n+2 is 0.
- R6: For an input pin, a masked data read returns the pad level through two flops. A pad change shows after the second rising clock edge and not after the first.
- R7: For an output pin, a masked data read returns the output-data bit whatever the pad level is.
- R8: Offsets outside the data window other than 0x400 read as 0. A write there changes neither register. Offsets 0x401 to 0x403 count as unmapped.
- R9: `padOut` always equals the output-data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 12 | Byte address of the access |
| wrEn | input | 1 | Write strobe, one cycle per write |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for `addr` |
| padIn | input | 8 | Pad input levels, asynchronous |
| padOut | output | 8 | Pad output levels |
| padOe | output | 8 | Pad output enables, 1 means driving |

## Verification
The bench writes and reads every one of the 256 masks, both with all pins as outputs and with a mixed direction pattern. A design that decoded the mask off by one address bit, or that ignored the mask, would corrupt bits that were not selected or leak them into the read data. Writes to pins that are inputs are followed by a switch to output, so a design that stored those writes shows the wrong pad level. The pad is toggled and read after one edge and after two edges, which catches a synchronizer that is too short or too long. Near-miss offsets (0x401, 0x404, 0x800) are written and read back, which catches a decoder that compares too few address bits.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  // Strobes from the address decoder to the register datapath
  typedef struct packed {
    logic dataSel;  // access falls in the masked data window
    logic dirSel;   // access hits the direction register
    logic dataWr;   // write into the data window
    logic dirWr;    // write into the direction register
  } gpioStrb_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[s] <= '0;
        else if (s == 0) stage[s] <= din;
        else stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign dout = stage[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk
      logic [1:0] warm;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
      end
      // R6: the output follows the input after exactly two edges
      a_r6_two_edge_latency: assert property (@(posedge clk) disable iff (!rstN)
        (warm == 2'd3) |-> (dout == $past(din, 2)));
    end
  endgenerate
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int PINS       = 8,
  parameter int ADDR_W     = 12,
  parameter int DIR_OFFSET = 'h400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  output gpioStrb_t         strb,
  output logic [PINS-1:0]   mask
);
  localparam int MASK_LO = 2;
  localparam int MASK_HI = PINS + MASK_LO - 1;
  localparam int WIN_LSB = PINS + MASK_LO;
  localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(DIR_OFFSET);

  logic inWindow;
  logic atDir;

  assign inWindow = (addr[ADDR_W-1:WIN_LSB] == '0);
  assign atDir    = (addr == DIR_ADDR);
  assign mask     = addr[MASK_HI:MASK_LO];

  always_comb begin
    strb         = '0;
    strb.dataSel = inWindow;
    strb.dirSel  = atDir && !inWindow;
    strb.dataWr  = inWindow && wrEn;
    strb.dirWr   = strb.dirSel && wrEn;
  end

  // R8: a write strobe fires only for the mapped target of the current address
  a_r8_write_targets: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dataWr || strb.dirWr) |-> (wrEn && (inWindow || atDir)));
endmodule

// File: rtl/gpio_dpath.sv
module gpio_dpath
  import gpio_pkg::*;
#(
  parameter int PINS        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  gpioStrb_t       strb,
  input  logic [PINS-1:0] mask,
  input  logic [PINS-1:0] wrData,
  output logic [PINS-1:0] rdData,
  input  logic [PINS-1:0] padIn,
  output logic [PINS-1:0] padOut,
  output logic [PINS-1:0] padOe
);
  logic [PINS-1:0] dirReg;
  logic [PINS-1:0] outData;
  logic [PINS-1:0] syncIn;
  logic [PINS-1:0] pinView;
  logic [PINS-1:0] wrSel;

  gpio_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rstN (rstN),
    .din  (padIn),
    .dout (syncIn)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dirReg <= '0;
    else if (strb.dirWr) dirReg <= wrData;
  end

  // Only selected bits of pins that are outputs take the write
  assign wrSel = mask & dirReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outData <= '0;
    else if (strb.dataWr) outData <= (outData & ~wrSel) | (wrData & wrSel);
  end

  assign pinView = (outData & dirReg) | (syncIn & ~dirReg);

  always_comb begin
    if (strb.dirSel)       rdData = dirReg;
    else if (strb.dataSel) rdData = pinView & mask;
    else                   rdData = '0;
  end

  assign padOut = outData;
  assign padOe  = dirReg;

  // R2: a direction write lands in full on the next edge
  a_r2_dir_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.dirWr |=> (padOe == $past(wrData)));
  // R2: without a direction write the direction holds
  a_r2_dir_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.dirWr |=> $stable(padOe));
  // R3 / R4: only selected output bits may change on a data write
  a_r3_masked_update: assert property (@(posedge clk) disable iff (!rstN)
    strb.dataWr |=> (((padOut ^ $past(padOut)) & ~($past(mask) & $past(padOe))) == '0));
  // R4: input pins never change their output-data bit
  a_r4_input_hold: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((padOut ^ $past(padOut)) & ~$past(padOe)) == '0));
  // R5: bits outside the mask read as zero
  a_r5_unmasked_zero: assert property (@(posedge clk) disable iff (!rstN)
    strb.dataSel |-> ((rdData & ~mask) == '0));
  // R8: unmapped offsets read zero
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.dataSel || strb.dirSel) |-> (rdData == '0));
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_pkg::*;
#(
  parameter int PINS        = 8,
  parameter int ADDR_W      = 12,
  parameter int DIR_OFFSET  = 'h400,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [PINS-1:0]   wrData,
  output logic [PINS-1:0]   rdData,
  input  logic [PINS-1:0]   padIn,
  output logic [PINS-1:0]   padOut,
  output logic [PINS-1:0]   padOe
);
  gpioStrb_t       strb;
  logic [PINS-1:0] mask;

  gpio_ctrl #(.PINS(PINS), .ADDR_W(ADDR_W), .DIR_OFFSET(DIR_OFFSET)) ctrl_i (
    .clk  (clk),
    .rstN (rstN),
    .addr (addr),
    .wrEn (wrEn),
    .strb (strb),
    .mask (mask)
  );

  gpio_dpath #(.PINS(PINS), .SYNC_STAGES(SYNC_STAGES)) dpath_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .mask   (mask),
    .wrData (wrData),
    .rdData (rdData),
    .padIn  (padIn),
    .padOut (padOut),
    .padOe  (padOe)
  );
endmodule

// File: tb/gpio_mask_port_tb.sv
module gpio_mask_port_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] addr = '0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [7:0]  padIn = '0;
  logic [7:0]  padOut;
  logic [7:0]  padOe;

  int  tests = 0;
  int  fails = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  gpio_mask_port dut_i (
    .clk (clk), .rstN (rstN), .addr (addr), .wrEn (wrEn), .wrData (wrData),
    .rdData (rdData), .padIn (padIn), .padOut (padOut), .padOe (padOe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; wrEn = 1'b0;
    #1 v = rdData;
  endtask

  function automatic logic [11:0] maskAddr(input logic [7:0] m);
    return {2'b00, m, 2'b00};
  endfunction

  initial begin
    logic [7:0] v;
    logic [7:0] model;
    logic [7:0] dir;
    logic [7:0] wd;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    #1;
    check("R1 padOe", padOe, 8'h00);
    check("R1 padOut", padOut, 8'h00);
    busRead(12'h400, v);
    check("R1 dir read", v, 8'h00);

    // R2: direction register load and readback
    busWrite(12'h400, 8'h5A);
    busRead(12'h400, v);
    check("R2 dir read", v, 8'h5A);
    check("R2 padOe", padOe, 8'h5A);

    // R3: sweep all masks with every pin an output
    busWrite(12'h400, 8'hFF);
    model = 8'h00;
    for (int m = 0; m < 256; m++) begin
      wd = 8'((m * 37) ^ 8'hC3);
      busWrite(maskAddr(8'(m)), wd);
      model = (model & ~8'(m)) | (wd & 8'(m));
      #1 check("R3 masked write", padOut, model);
      check("R9 padOut", padOut, model);
    end

    // R5 / R7: masked reads of output pins, pad noise ignored
    padIn = 8'h96;
    repeat (3) @(negedge clk);
    for (int m = 0; m < 256; m++) begin
      busRead(maskAddr(8'(m)), v);
      check("R5 R7 masked read", v, model & 8'(m));
    end

    // R4: writes to input pins are dropped
    busWrite(12'h400, 8'h00);
    busWrite(12'h3FC, ~model);
    busWrite(12'h400, 8'hFF);
    #1 check("R4 old value kept", padOut, model);
    busWrite(12'h3FC, ~model);
    model = ~model;
    #1 check("R4 rewrite after switch", padOut, model);

    // Mixed directions: writes and reads over all masks
    dir = 8'hA5;
    busWrite(12'h400, dir);
    padIn = 8'h3C;
    repeat (3) @(negedge clk);
    for (int m = 0; m < 256; m++) begin
      wd = 8'(m * 11 + 5);
      busWrite(maskAddr(8'(m)), wd);
      model = (model & ~(8'(m) & dir)) | (wd & 8'(m) & dir);
      busRead(maskAddr(8'(m)), v);
      check("R3 R6 R7 mixed read", v, ((model & dir) | (padIn & ~dir)) & 8'(m));
    end
    #1 check("R4 mixed padOut", padOut, model);

    // R6: two-edge synchronizer latency on input pins
    busWrite(12'h400, 8'h00);
    @(negedge clk);
    addr = 12'h3FC;
    padIn = 8'hC9;
    @(negedge clk);
    #1 check("R6 after one edge", rdData, 8'h3C);
    @(negedge clk);
    #1 check("R6 after two edges", rdData, 8'hC9);

    // R8: unmapped offsets
    busWrite(12'h400, 8'hF0);
    busWrite(12'h3FC, 8'h00);
    model = model & 8'h0F;
    busWrite(12'h404, 8'hFF);
    busWrite(12'h401, 8'h0F);
    busWrite(12'h800, 8'hFF);
    busWrite(12'hC3C, 8'hFF);
    busRead(12'h404, v);
    check("R8 read 0x404", v, 8'h00);
    busRead(12'h401, v);
    check("R8 read 0x401", v, 8'h00);
    busRead(12'h800, v);
    check("R8 read 0x800", v, 8'h00);
    busRead(12'h400, v);
    check("R8 dir untouched", v, 8'hF0);
    #1 check("R8 data untouched", padOut, model);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule